// File: doc/BRIEF.md
# DMA Channel Enable and Abort Controller

This block is the control logic of a single DMA channel. It holds the channel's configuration: source address, destination address, remaining transfer count, block size and transfer mode. It also holds a channel-active bit and a block-error flag. While the channel is active it issues one bus-cycle request per transfer on a request/acknowledge handshake. It can run in single mode, where each transfer request yields one transfer. It can run in burst mode, where transfers follow each other with no request. It can run in block mode, where each transfer request yields a whole block. Address generation and the bus fabric sit outside the block.

Software stops the channel by writing 0 to the active bit. The stop is deferred. In single mode the bus cycle in progress finishes. In burst mode at most three more transfers complete. In block mode the block in progress finishes. The active bit reads 1 until the channel is idle. While it reads 1, configuration writes are dropped. Software therefore writes 0, polls the bit until it reads 0, and then reprograms the channel.

A non-maskable interrupt aborts a block in progress and sets the error flag. A standby request aborts a block in progress without setting the flag.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset, the control word reads 0, `bus_req` and `done` are low, and the remaining count reads 0. Reset in the middle of a run has the same result.
- R2: While the active bit is 1, writes to source (address 1), destination (address 2), count (address 3) and block size (address 4) are ignored. Writes to the mode field of the control word (address 0) are also ignored.
- R3: `bus_req` stays high until `bus_ack` is seen. A bus cycle completes in any cycle where both are high. In single mode (mode field 0) one `xfer_req` pulse gives exactly one bus cycle.
- R4: In burst mode (mode field 1) the channel runs with no request. After a 0 is written to the active bit, exactly three more bus cycles complete, unless the count runs out first. The remaining count then reads its start value minus the transfers made.
- R5: The active bit reads 1 from the cycle of the 0-write until the last outstanding bus cycle has completed. Whenever the active bit is 0, `bus_req` is low.
- R6: In block mode (mode field 2) one `xfer_req` gives block-size transfers. A block size of 0 counts as 1. A block stops early only when the remaining count reaches zero.
- R7: A 0-write to the active bit during a block lets the block run to its end before the channel goes idle.
- R8: `nmi` during a block in progress stops the block on the next edge, drops `bus_req`, clears the active bit and sets the error flag (control bit 1). `nmi` has no effect when no block is in progress.
- R9: `standby` during a block in progress aborts it like R8, but leaves the error flag unchanged.
- R10: Only a control write with bit 1 at 0, or reset, clears the error flag. A control write with bit 1 at 1 leaves the flag set.
- R11: Each completed bus cycle lowers the count by one. When the count reaches zero, the active bit clears and `done` is high for exactly one cycle.
- R12: A control write with bit 0 at 1 while idle starts the channel. Once the active bit reads 0 after a stop, new configuration writes take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address (0 control, 1 source, 2 destination, 3 count, 4 block size) |
| wr_data | input | AW | Write data. In the control word, bit 0 is active, bit 1 is error, bits 3:2 are mode |
| rd_addr | input | 3 | Read register address |
| rd_data | output | AW | Read data, combinational from `rd_addr` |
| xfer_req | input | 1 | Transfer request |
| nmi | input | 1 | Non-maskable abort |
| standby | input | 1 | Standby entry |
| bus_req | output | 1 | Bus-cycle request |
| bus_ack | input | 1 | Bus-cycle acknowledge |
| done | output | 1 | One-cycle pulse when the count reaches zero |

## Verification
A wrong internal state shows at the ports within a few cycles. A drain counter that is off by one shows as one transfer too many or too few on `bus_req`/`bus_ack` after the stop write. A lost block counter cuts a block short, or lets it run past its size, within one block time. A lock that fails changes a register read back at once. A stuck busy state shows at once as `bus_req` high while the active bit reads 0. An abort that is applied wrongly shows in the control word on the edge after `nmi` or `standby`.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
    localparam logic [1:0] MODE_SINGLE = 2'd0;
    localparam logic [1:0] MODE_BURST  = 2'd1;
    localparam logic [1:0] MODE_BLOCK  = 2'd2;

    localparam logic [2:0] ADDR_CTRL  = 3'd0;
    localparam logic [2:0] ADDR_SRC   = 3'd1;
    localparam logic [2:0] ADDR_DST   = 3'd2;
    localparam logic [2:0] ADDR_COUNT = 3'd3;
    localparam logic [2:0] ADDR_BLK   = 3'd4;

    localparam int DRAIN_MAX = 3;
    localparam int DRAIN_W   = $clog2(DRAIN_MAX + 1);
endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
    import dma_chan_pkg::*;
#(
    parameter int AW = 32,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [2:0]    addr,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic [BW-1:0] blksize,
    output logic [1:0]    mode
);
    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [BW-1:0] blk;
        logic [1:0]    mode;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (addr)
                ADDR_CTRL: cfg_d.mode = wdata[3:2];
                ADDR_SRC:  cfg_d.src  = wdata;
                ADDR_DST:  cfg_d.dst  = wdata;
                ADDR_BLK:  cfg_d.blk  = wdata[BW-1:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            cfg_q.blk  <= BW'(1);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign src     = cfg_q.src;
    assign dst     = cfg_q.dst;
    assign blksize = cfg_q.blk;
    assign mode    = cfg_q.mode;
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
    import dma_chan_pkg::*;
#(
    parameter int CW = 16,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_we,
    input  logic [1:0]    ctrl_wdata,
    input  logic          cnt_we,
    input  logic [CW-1:0] cnt_wdata,
    input  logic [1:0]    mode,
    input  logic [BW-1:0] blksize,
    input  logic          req,
    input  logic          nmi,
    input  logic          standby,
    input  logic          bus_ack,
    output logic          active,
    output logic          err,
    output logic [CW-1:0] count,
    output logic          bus_req,
    output logic          done,
    output logic          blk_busy
);
    typedef struct packed {
        logic               active;
        logic               err;
        logic               stop;
        logic               busy;
        logic               done;
        logic [DRAIN_W-1:0] drain;
        logic [CW-1:0]      cnt;
        logic [BW-1:0]      blk;
    } seq_t;

    seq_t s_d, s_q;

    logic          complete;
    logic          stop_wr;
    logic          stopping;
    logic          ahead;
    logic          go;
    logic [BW-1:0] blk_load;

    assign blk_load = (blksize == '0) ? BW'(1) : blksize;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        go       = 1'b0;
        complete = s_q.busy && bus_ack;
        stop_wr  = ctrl_we && !ctrl_wdata[0];
        stopping = s_q.stop || stop_wr;

        if (complete) begin
            s_d.busy = 1'b0;
            s_d.cnt  = s_q.cnt - CW'(1);
            if (s_q.blk != '0)   s_d.blk   = s_q.blk - BW'(1);
            if (s_q.drain != '0) s_d.drain = s_q.drain - DRAIN_W'(1);
        end

        case (mode)
            MODE_BURST: ahead = (s_d.drain != '0);
            MODE_BLOCK: ahead = (s_d.blk != '0);
            default:    ahead = 1'b0;
        endcase

        if (s_q.active) begin
            if ((nmi || standby) && s_q.blk != '0) begin
                s_d.active = 1'b0;
                s_d.busy   = 1'b0;
                s_d.stop   = 1'b0;
                s_d.blk    = '0;
                s_d.drain  = '0;
                if (nmi) s_d.err = 1'b1;
            end else if ((complete && s_q.cnt == CW'(1)) ||
                         (!s_q.busy && s_q.cnt == '0)) begin
                s_d.active = 1'b0;
                s_d.done   = 1'b1;
                s_d.stop   = 1'b0;
                s_d.blk    = '0;
                s_d.drain  = '0;
            end else if (s_q.stop && !s_d.busy && !ahead) begin
                s_d.active = 1'b0;
                s_d.stop   = 1'b0;
            end else begin
                if (stop_wr && !s_q.stop) begin
                    s_d.stop = 1'b1;
                    if (mode == MODE_BURST) s_d.drain = DRAIN_W'(DRAIN_MAX);
                end
                if (!s_q.busy) begin
                    case (mode)
                        MODE_BURST: go = !stopping || (s_d.drain != '0);
                        MODE_BLOCK: begin
                            if (s_q.blk != '0) begin
                                go = 1'b1;
                            end else if (req && !stopping) begin
                                go      = 1'b1;
                                s_d.blk = blk_load;
                            end
                        end
                        default:    go = req && !stopping;
                    endcase
                end
                if (go) s_d.busy = 1'b1;
            end
        end else begin
            if (ctrl_we && ctrl_wdata[0]) begin
                s_d.active = 1'b1;
                s_d.stop   = 1'b0;
                s_d.blk    = '0;
                s_d.drain  = '0;
            end
            if (ctrl_we && !ctrl_wdata[1]) s_d.err = 1'b0;
            if (cnt_we) s_d.cnt = cnt_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active   = s_q.active;
    assign err      = s_q.err;
    assign count    = s_q.cnt;
    assign bus_req  = s_q.busy;
    assign done     = s_q.done;
    assign blk_busy = (s_q.blk != '0);
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
    import dma_chan_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [AW-1:0] wr_data,
    input  logic [2:0]    rd_addr,
    output logic [AW-1:0] rd_data,
    input  logic          xfer_req,
    input  logic          nmi,
    input  logic          standby,
    output logic          bus_req,
    input  logic          bus_ack,
    output logic          done
);
    logic          active;
    logic          err;
    logic          blk_busy;
    logic [CW-1:0] count;
    logic [AW-1:0] src;
    logic [AW-1:0] dst;
    logic [BW-1:0] blksize;
    logic [1:0]    mode;
    logic          cfg_we;
    logic          ctrl_we;
    logic          cnt_we;

    assign cfg_we  = wr_en && !active;
    assign ctrl_we = wr_en && (wr_addr == ADDR_CTRL);
    assign cnt_we  = cfg_we && (wr_addr == ADDR_COUNT);

    dma_cfg_regs #(.AW(AW), .BW(BW)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (wr_addr),
        .wdata   (wr_data),
        .src     (src),
        .dst     (dst),
        .blksize (blksize),
        .mode    (mode)
    );

    dma_xfer_seq #(.CW(CW), .BW(BW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (wr_data[1:0]),
        .cnt_we     (cnt_we),
        .cnt_wdata  (wr_data[CW-1:0]),
        .mode       (mode),
        .blksize    (blksize),
        .req        (xfer_req),
        .nmi        (nmi),
        .standby    (standby),
        .bus_ack    (bus_ack),
        .active     (active),
        .err        (err),
        .count      (count),
        .bus_req    (bus_req),
        .done       (done),
        .blk_busy   (blk_busy)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_CTRL:  rd_data[3:0]    = {mode, err, active};
            ADDR_SRC:   rd_data         = src;
            ADDR_DST:   rd_data         = dst;
            ADDR_COUNT: rd_data[CW-1:0] = count;
            ADDR_BLK:   rd_data[BW-1:0] = blksize;
            default:    ;
        endcase
    end
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk
    import dma_chan_pkg::*;
#(
    parameter int AW = 32,
    parameter int BW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [2:0]    wr_addr,
    input logic [1:0]    wr_low,
    input logic          active,
    input logic          err,
    input logic          bus_req,
    input logic          bus_ack,
    input logic          done,
    input logic          nmi,
    input logic          standby,
    input logic          blk_busy,
    input logic [1:0]    mode,
    input logic [AW-1:0] src,
    input logic [AW-1:0] dst,
    input logic [BW-1:0] blksize
);
    logic       trk_q;
    logic [2:0] tail_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q  <= 1'b0;
            tail_q <= '0;
        end else if (!active) begin
            trk_q  <= 1'b0;
            tail_q <= '0;
        end else if (!trk_q) begin
            if (wr_en && wr_addr == ADDR_CTRL && !wr_low[0] && mode == MODE_BURST)
                trk_q <= 1'b1;
        end else if (bus_req && bus_ack && tail_q != 3'd7) begin
            tail_q <= tail_q + 3'd1;
        end
    end

    assert_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        active && wr_en |=> $stable(src) && $stable(dst) && $stable(blksize) && $stable(mode));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack && !nmi && !standby |=> bus_req);

    assert_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q |-> tail_q <= 3'd3);

    assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !bus_req);

    assert_nmi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        active && blk_busy && nmi |=> !active && err);

    assert_standby_R9: assert property (@(posedge clk) disable iff (!rst_n)
        active && blk_busy && standby && !nmi |=> !active && (err == $past(err)));

    assert_errclr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err) |-> $past(wr_en && wr_addr == ADDR_CTRL && !wr_low[1]));

    assert_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !active && !bus_req);

    assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind dma_chan_ctl dma_chan_chk #(.AW(AW), .BW(BW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_low   (wr_data[1:0]),
    .active   (active),
    .err      (err),
    .bus_req  (bus_req),
    .bus_ack  (bus_ack),
    .done     (done),
    .nmi      (nmi),
    .standby  (standby),
    .blk_busy (blk_busy),
    .mode     (mode),
    .src      (src),
    .dst      (dst),
    .blksize  (blksize)
);

// File: tb/tb_dma_chan_ctl.sv
module tb_dma_chan_ctl;
    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_SRC  = 3'd1;
    localparam logic [2:0] A_CNT  = 3'd3;
    localparam logic [2:0] A_BLK  = 3'd4;

    typedef struct packed {
        logic [1:0]  mode;
        logic [15:0] cnt;
        logic [7:0]  blk;
        logic [3:0]  nreq;
        logic [15:0] exp;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{mode: 2'd0, cnt: 16'd3, blk: 8'd1, nreq: 4'd3, exp: 16'd3},
        '{mode: 2'd1, cnt: 16'd5, blk: 8'd1, nreq: 4'd0, exp: 16'd5},
        '{mode: 2'd2, cnt: 16'd8, blk: 8'd4, nreq: 4'd2, exp: 16'd8},
        '{mode: 2'd2, cnt: 16'd6, blk: 8'd4, nreq: 4'd2, exp: 16'd6},
        '{mode: 2'd1, cnt: 16'd1, blk: 8'd1, nreq: 4'd0, exp: 16'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        xfer_req = 1'b0;
    logic        nmi = 1'b0;
    logic        standby = 1'b0;
    logic        bus_req;
    logic        bus_ack;
    logic        done;
    logic        ack_en = 1'b1;

    int total = 0;
    int bad = 0;
    int xfers = 0;
    int dones = 0;

    always #5 clk = ~clk;

    assign bus_ack = bus_req & ack_en;

    dma_chan_ctl dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .xfer_req (xfer_req),
        .nmi      (nmi),
        .standby  (standby),
        .bus_req  (bus_req),
        .bus_ack  (bus_ack),
        .done     (done)
    );

    always @(posedge clk) begin
        if (rst_n && bus_req && bus_ack) xfers <= xfers + 1;
        if (rst_n && done) dones <= dones + 1;
    end

    task automatic report();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_quiet();
        int quiet = 0;
        while (quiet < 3) begin
            @(negedge clk);
            if (bus_req) quiet = 0;
            else quiet++;
        end
    endtask

    task automatic wait_inactive();
        logic [31:0] v;
        for (int i = 0; i < 1000; i++) begin
            rd(A_CTRL, v);
            if (!v[0]) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_req();
        @(negedge clk);
        xfer_req = 1'b1;
        @(negedge clk);
        xfer_req = 1'b0;
    endtask

    task automatic start(input logic [1:0] m, input logic [15:0] c, input logic [7:0] b);
        wr(A_CNT, {16'd0, c});
        wr(A_BLK, {24'd0, b});
        wr(A_CTRL, {28'd0, m, 2'b01});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [31:0] v;
        int base;
        int base_d;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(A_CTRL, v); chk("R1 ctrl after reset", v, 32'h0);
        chk("R1 bus_req after reset", {31'd0, bus_req}, 32'd0);
        chk("R1 done after reset", {31'd0, done}, 32'd0);

        // Vector table: R3 single, R4 burst, R6 block, R11 count/done
        foreach (VECS[k]) begin
            base   = xfers;
            base_d = dones;
            start(VECS[k].mode, VECS[k].cnt, VECS[k].blk);
            for (int r = 0; r < int'(VECS[k].nreq); r++) begin
                pulse_req();
                wait_quiet();
            end
            wait_inactive();
            chk("R6 R3 transfers per vector", 32'(xfers - base), 32'(VECS[k].exp));
            chk("R11 one done pulse", 32'(dones - base_d), 32'd1);
            rd(A_CNT, v); chk("R11 count drained", v, 32'd0);
        end

        // R2 / R3 / R5: single mode with the bus stalled
        wr(A_SRC, 32'hA5A5);
        ack_en = 1'b0;
        start(2'd0, 16'd10, 8'd1);
        base = xfers;
        pulse_req();
        wr(A_SRC, 32'h1234);
        rd(A_SRC, v); chk("R2 source locked", v, 32'hA5A5);
        wr(A_CNT, 32'd77);
        rd(A_CNT, v); chk("R2 count locked", v, 32'd10);
        wr(A_CTRL, 32'h5);
        rd(A_CTRL, v); chk("R2 mode locked", {30'd0, v[3:2]}, 32'd0);
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, v); chk("R5 active held during stop", {31'd0, v[0]}, 32'd1);
        repeat (4) @(negedge clk);
        chk("R3 bus_req held without ack", {31'd0, bus_req}, 32'd1);
        ack_en = 1'b1;
        wait_inactive();
        chk("R3 single stop one transfer", 32'(xfers - base), 32'd1);
        pulse_req();
        repeat (3) @(negedge clk);
        chk("R5 no transfer once idle", 32'(xfers - base), 32'd1);
        rd(A_CNT, v); chk("R11 count after one transfer", v, 32'd9);
        wr(A_SRC, 32'h1234);
        rd(A_SRC, v); chk("R12 write after stop applies", v, 32'h1234);

        // R4: burst drain
        base = xfers;
        start(2'd1, 16'd100, 8'd1);
        repeat (9) @(negedge clk);
        wr(A_CTRL, 32'h4);
        base_d = xfers;
        rd(A_CTRL, v); chk("R5 active reads 1 after burst stop", {31'd0, v[0]}, 32'd1);
        wait_inactive();
        chk("R4 three transfers after stop", 32'(xfers - base_d), 32'd3);
        rd(A_CNT, v); chk("R4 remaining count", v, 32'(100 - (xfers - base)));

        // R7: stop during block completes the block
        base = xfers;
        start(2'd2, 16'd50, 8'd6);
        pulse_req();
        repeat (3) @(negedge clk);
        wr(A_CTRL, 32'h8);
        rd(A_CTRL, v); chk("R7 active during block stop", {31'd0, v[0]}, 32'd1);
        wait_inactive();
        chk("R7 full block after stop", 32'(xfers - base), 32'd6);

        // R8: nmi mid-block
        base = xfers;
        start(2'd2, 16'd50, 8'd8);
        pulse_req();
        repeat (4) @(negedge clk);
        nmi = 1'b1;
        @(negedge clk);
        nmi = 1'b0;
        rd(A_CTRL, v); chk("R8 nmi clears active sets error", {30'd0, v[1:0]}, 32'h2);
        chk("R8 bus_req dropped", {31'd0, bus_req}, 32'd0);
        chk("R8 block cut short", {31'd0, (xfers - base) > 0 && (xfers - base) < 8}, 32'd1);
        rd(A_CNT, v); chk("R8 count matches transfers", v, 32'(50 - (xfers - base)));
        wr(A_CTRL, 32'hA);
        rd(A_CTRL, v); chk("R10 write of 1 keeps error", {31'd0, v[1]}, 32'd1);
        wr(A_CTRL, 32'h8);
        rd(A_CTRL, v); chk("R10 write of 0 clears error", {31'd0, v[1]}, 32'd0);

        // R9: standby mid-block
        base = xfers;
        start(2'd2, 16'd50, 8'd8);
        pulse_req();
        repeat (4) @(negedge clk);
        standby = 1'b1;
        @(negedge clk);
        standby = 1'b0;
        rd(A_CTRL, v); chk("R9 standby aborts without error", {30'd0, v[1:0]}, 32'h0);
        chk("R9 block cut short", {31'd0, (xfers - base) < 8}, 32'd1);

        // R8: nmi outside a block has no effect
        start(2'd0, 16'd5, 8'd1);
        @(negedge clk);
        nmi = 1'b1;
        @(negedge clk);
        nmi = 1'b0;
        rd(A_CTRL, v); chk("R8 nmi ignored outside block", {30'd0, v[1:0]}, 32'h1);
        wr(A_CTRL, 32'h0);
        wait_inactive();

        // R1: reset in the middle of a burst
        start(2'd1, 16'd200, 8'd1);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(A_CTRL, v); chk("R1 ctrl after mid-run reset", v, 32'h0);
        rd(A_CNT, v); chk("R1 count after mid-run reset", v, 32'h0);
        chk("R1 bus_req after mid-run reset", {31'd0, bus_req}, 32'd0);

        report();
    end
endmodule